// File: doc/BRIEF.md
# Prefilter Gain and Offset Stage

This block scales a stream of signed fixed-point I/Q sample pairs by a programmable gain and then adds a programmable offset on each lane, limiting the result to the normalised interval from -1 to +1. Samples arrive and leave on a valid/ready stream. The gain may exceed unity in magnitude (up to about ±2), which lets the stage boost as well as attenuate. A mode input chooses whether only the I lane is processed (real) or both lanes are (complex).

The datapath has two register stages: the first forms the product and aligns the offset, and the second adds, rescales, saturates and holds the result. Both stages advance only when the downstream side is ready, and the upstream ready is the downstream ready passed through. A small state machine keeps a sticky overflow flag. It has two states, FLAG_IDLE and FLAG_HELD. The transition SET_ON_CLAMP moves FLAG_IDLE to FLAG_HELD when a clamped result is captured. The transition CLEAR_BY_REQ moves FLAG_HELD back to FLAG_IDLE when the clear request is high and no clamp is captured in that cycle. KEEP_HELD and KEEP_IDLE leave the state as it is.

Top module: `pfg_gain_offset`

## Requirements
- R1: `in_ready` equals `out_ready` in every cycle.
- R2: After reset `out_valid` is 0. A pair accepted on edge k with `out_ready` high on edge k+1 is shown with `out_valid` high from edge k+1 onward (two cycles of latency).
- R3: Samples are signed Q1.15, `gain` is signed Q2.16 (18 bits) and `offset` is signed Q1.17 (18 bits). Gain, offset and mode are sampled together with the pair. Each active lane outputs floor((s·g + o·2^14) / 2^16) when that value lies in [-32768, 32767]. A gain of 0x10000 with a zero offset returns the sample unchanged.
- R4: A result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R5: `ovf_flag` goes high in the same cycle a clamped result first appears on the output, and it stays high until `ovf_clear` is seen in a cycle where no new clamp is captured. A clamp captured in the same cycle as a clear leaves the flag high.
- R6: `complex_mode` = 1 processes both lanes. `complex_mode` = 0 processes only I: `out_q` is 0, and a Q-lane value that would clamp does not set `ovf_flag`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_i` and `out_q` hold their values.
- R8: After reset `ovf_flag`, `out_i` and `out_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input accepted when high with in_valid |
| in_i | input | 16 | I sample, signed Q1.15 |
| in_q | input | 16 | Q sample, signed Q1.15 |
| gain | input | 18 | Gain, signed Q2.16 |
| offset | input | 18 | Offset, signed Q1.17 |
| complex_mode | input | 1 | 1 = both lanes, 0 = I lane only |
| ovf_clear | input | 1 | Request to clear the overflow flag |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream ready |
| out_i | output | 16 | I result, signed Q1.15 |
| out_q | output | 16 | Q result, signed Q1.15 |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The hardest situation to reach from the ports is a clamp that is captured in the same cycle as a clear request, because a clear normally lands when no sample is moving. The stimulus holds the clear high across a directed saturating beat and checks that the flag still rises. Random ready drops hold results in the output register while new pairs wait in the first stage, which exercises the stall-hold rule and the flag path under back-pressure. Random gains span the full ±2 range, so results clamp in both directions often, and real-mode beats with extreme Q values confirm that the Q lane has no effect.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    localparam int LANES = 2;

    typedef enum logic [0:0] {
        FLAG_IDLE = 1'b0,
        FLAG_HELD = 1'b1
    } flag_state_e;

endpackage

// File: rtl/pfg_mult_lane.sv
module pfg_mult_lane #(
    parameter int SW    = 16,
    parameter int GW    = 18,
    parameter int OW    = 18,
    parameter int ALIGN = 14,
    localparam int PW   = SW + GW,
    localparam int SUMW = PW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic signed [SW-1:0]   sample,
    input  logic signed [GW-1:0]   gain,
    input  logic signed [OW-1:0]   offset,
    output logic signed [PW-1:0]   prod,
    output logic signed [SUMW-1:0] off_al
);

    logic signed [PW-1:0]   prod_c;
    logic signed [SUMW-1:0] off_c;

    always_comb begin
        prod_c = PW'(sample) * PW'(gain);
        off_c  = {{(SUMW-OW-ALIGN){offset[OW-1]}}, offset, {ALIGN{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod   <= '0;
            off_al <= '0;
        end else if (en) begin
            prod   <= prod_c;
            off_al <= off_c;
        end
    end

endmodule

// File: rtl/pfg_sat_lane.sv
module pfg_sat_lane #(
    parameter int SW    = 16,
    parameter int GW    = 18,
    parameter int SHIFT = 16,
    localparam int PW   = SW + GW,
    localparam int SUMW = PW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   active,
    input  logic signed [PW-1:0]   prod,
    input  logic signed [SUMW-1:0] off_al,
    output logic signed [SW-1:0]   result,
    output logic                   clamp_now
);

    localparam logic signed [SUMW-1:0] MAX_V = SUMW'((1 << (SW-1)) - 1);
    localparam logic signed [SUMW-1:0] MIN_V = -MAX_V - SUMW'(1);

    logic signed [SUMW-1:0] sum_c;
    logic signed [SUMW-1:0] scaled_c;
    logic signed [SW-1:0]   res_c;

    always_comb begin
        sum_c     = SUMW'(prod) + off_al;
        scaled_c  = sum_c >>> SHIFT;
        clamp_now = 1'b0;
        if (!active) begin
            res_c = '0;
        end else if (scaled_c > MAX_V) begin
            res_c     = MAX_V[SW-1:0];
            clamp_now = 1'b1;
        end else if (scaled_c < MIN_V) begin
            res_c     = MIN_V[SW-1:0];
            clamp_now = 1'b1;
        end else begin
            res_c = scaled_c[SW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (en) begin
            result <= res_c;
        end
    end

endmodule

// File: rtl/pfg_flag_fsm.sv
module pfg_flag_fsm
    import pfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clamp_hit,
    input  logic clear_req,
    output logic flag
);

    flag_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FLAG_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FLAG_IDLE: begin
                if (clamp_hit) begin
                    state_nx = FLAG_HELD;
                end
            end
            FLAG_HELD: begin
                if (clear_req && !clamp_hit) begin
                    state_nx = FLAG_IDLE;
                end
            end
            default: state_nx = FLAG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            FLAG_HELD: flag = 1'b1;
            default:   flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/pfg_gain_offset.sv
module pfg_gain_offset #(
    parameter int SW    = 16,
    parameter int GW    = 18,
    parameter int OW    = 18,
    parameter int SFRAC = 15,
    parameter int GFRAC = 16,
    parameter int OFRAC = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [SW-1:0] in_i,
    input  logic [SW-1:0] in_q,
    input  logic [GW-1:0] gain,
    input  logic [OW-1:0] offset,
    input  logic          complex_mode,
    input  logic          ovf_clear,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [SW-1:0] out_i,
    output logic [SW-1:0] out_q,
    output logic          ovf_flag
);
    import pfg_pkg::*;

    localparam int ALIGN = SFRAC + GFRAC - OFRAC;
    localparam int PW    = SW + GW;
    localparam int SUMW  = PW + 1;

    logic                   en;
    logic                   s1_valid;
    logic                   s1_cplx;
    logic                   s2_cplx;
    logic [LANES-1:0]       lane_active;
    logic [LANES-1:0]       lane_clamp;
    logic                   clamp_hit;
    logic signed [SW-1:0]   lane_in  [LANES];
    logic signed [SW-1:0]   lane_out [LANES];
    logic signed [PW-1:0]   lane_prod [LANES];
    logic signed [SUMW-1:0] lane_off  [LANES];

    assign en       = out_ready;
    assign in_ready = out_ready;

    assign lane_in[0]     = in_i;
    assign lane_in[1]     = in_q;
    assign lane_active[0] = 1'b1;
    assign lane_active[1] = s1_cplx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_cplx   <= 1'b0;
            out_valid <= 1'b0;
            s2_cplx   <= 1'b0;
        end else if (en) begin
            s1_valid  <= in_valid;
            s1_cplx   <= complex_mode;
            out_valid <= s1_valid;
            s2_cplx   <= s1_cplx;
        end
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        pfg_mult_lane #(
            .SW(SW), .GW(GW), .OW(OW), .ALIGN(ALIGN)
        ) u_mult (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en),
            .sample (lane_in[ln]),
            .gain   ($signed(gain)),
            .offset ($signed(offset)),
            .prod   (lane_prod[ln]),
            .off_al (lane_off[ln])
        );

        pfg_sat_lane #(
            .SW(SW), .GW(GW), .SHIFT(GFRAC)
        ) u_sat (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en),
            .active    (lane_active[ln]),
            .prod      (lane_prod[ln]),
            .off_al    (lane_off[ln]),
            .result    (lane_out[ln]),
            .clamp_now (lane_clamp[ln])
        );
    end

    assign clamp_hit = en && s1_valid && (|lane_clamp);
    assign out_i     = lane_out[0];
    assign out_q     = lane_out[1];

    pfg_flag_fsm u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .clamp_hit (clamp_hit),
        .clear_req (ovf_clear),
        .flag      (ovf_flag)
    );

endmodule

// File: rtl/pfg_gain_offset_chk.sv
module pfg_gain_offset_chk #(
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [SW-1:0] out_i,
    input logic [SW-1:0] out_q,
    input logic          ovf_flag,
    input logic          ovf_clear,
    input logic          s2_cplx
);

    localparam logic [SW-1:0] TOP_V = {1'b0, {(SW-1){1'b1}}};
    localparam logic [SW-1:0] BOT_V = {1'b1, {(SW-1){1'b0}}};

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 out_ready |=> out_valid);

    assert_clamp_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> out_valid &&
            (out_i == TOP_V || out_i == BOT_V || out_q == TOP_V || out_q == BOT_V));

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clear |=> ovf_flag);

    assert_real_q_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !s2_cplx |-> out_q == '0);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q));

endmodule

bind pfg_gain_offset pfg_gain_offset_chk #(.SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_i     (out_i),
    .out_q     (out_q),
    .ovf_flag  (ovf_flag),
    .ovf_clear (ovf_clear),
    .s2_cplx   (s2_cplx)
);

// File: tb/pfg_gain_offset_test.sv
module pfg_gain_offset_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic [17:0] gain = '0;
    logic [17:0] offset = '0;
    logic        complex_mode = 1'b0;
    logic        ovf_clear = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_i;
    logic [15:0] out_q;
    logic        ovf_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct { int vi; int vq; bit sat; } exp_t;
    exp_t scb[$];

    always #4 clk = ~clk;

    pfg_gain_offset uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .gain(gain), .offset(offset),
        .complex_mode(complex_mode), .ovf_clear(ovf_clear),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_i(out_i), .out_q(out_q), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void lane_model(input int s, input int g, input int o,
                                       output int val, output bit sat);
        longint p;
        p = longint'(s) * longint'(g) + (longint'(o) <<< 14);
        p = p >>> 16;
        sat = 1'b0;
        if (p > 32767) begin val = 32767; sat = 1'b1; end
        else if (p < -32768) begin val = -32768; sat = 1'b1; end
        else val = int'(p);
    endfunction

    function automatic exp_t pair_model(input logic [15:0] si, input logic [15:0] sq,
                                        input logic [17:0] g, input logic [17:0] o,
                                        input bit cplx);
        exp_t e;
        int vi, vq;
        bit si_sat, sq_sat;
        lane_model($signed(si), $signed(g), $signed(o), vi, si_sat);
        lane_model($signed(sq), $signed(g), $signed(o), vq, sq_sat);
        e.vi  = vi;
        e.vq  = cplx ? vq : 0;
        e.sat = si_sat | (cplx & sq_sat);
        return e;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // one beat with ready held high; checks latency, value and flag
    task automatic send_one(input logic [15:0] si, input logic [15:0] sq,
                            input logic [17:0] g, input logic [17:0] o,
                            input bit cplx, input bit exp_flag, input string req);
        exp_t e;
        e = pair_model(si, sq, g, o, cplx);
        @(negedge clk);
        in_valid = 1'b1; in_i = si; in_q = sq; gain = g; offset = o;
        complex_mode = cplx; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R2", "out_valid one cycle after accept", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2", "out_valid two cycles after accept", out_valid, 1);
        chk($signed(out_i) == e.vi, req, "out_i", $signed(out_i), e.vi);
        chk($signed(out_q) == e.vq, req, "out_q", $signed(out_q), e.vq);
        chk(ovf_flag == exp_flag, req, "ovf_flag", ovf_flag, exp_flag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin : main
        int seed_dummy;
        bit prev_stall;
        logic [15:0] prev_i, prev_q;
        seed_dummy = $urandom(32'h5EED_2024);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 / R2 reset state
        chk(out_valid == 1'b0, "R2", "out_valid after reset", out_valid, 0);
        chk(ovf_flag == 1'b0, "R8", "ovf_flag after reset", ovf_flag, 0);
        chk(out_i == '0, "R8", "out_i after reset", out_i, 0);
        chk(out_q == '0, "R8", "out_q after reset", out_q, 0);

        // R1 pass-through in both directions
        out_ready = 1'b0; #1;
        chk(in_ready == 1'b0, "R1", "in_ready with out_ready low", in_ready, 0);
        out_ready = 1'b1; #1;
        chk(in_ready == 1'b1, "R1", "in_ready with out_ready high", in_ready, 1);

        // R3 unity gain passes sample unchanged
        send_one(16'd12345, 16'hC000, 18'h10000, 18'h0, 1'b1, 1'b0, "R3");
        // R3 half gain, negative sample, floor
        send_one(16'hFC17, 16'd1001, 18'h08000, 18'h0, 1'b1, 1'b0, "R3");
        // R3 offset added after gain
        send_one(16'd0, 16'd8000, 18'h3F000, 18'h10000, 1'b1, 1'b0, "R3");
        // R4 positive clamp, flag sets (R5)
        send_one(16'd30000, 16'd5, 18'h1FFFF, 18'h0, 1'b1, 1'b1, "R4");
        // R5 flag stays with no clear
        send_one(16'd100, 16'd100, 18'h10000, 18'h0, 1'b1, 1'b1, "R5");
        // R5 clear
        @(negedge clk); ovf_clear = 1'b1;
        @(negedge clk); ovf_clear = 1'b0;
        chk(ovf_flag == 1'b0, "R5", "ovf_flag after clear", ovf_flag, 0);
        // R4 negative clamp on Q lane in complex mode
        send_one(16'd10, 16'h8000, 18'h1FFFF, 18'h30000, 1'b1, 1'b1, "R4");
        @(negedge clk); ovf_clear = 1'b1;
        @(negedge clk); ovf_clear = 1'b0;
        // R6 real mode: Q extreme does not clamp or set flag, out_q zero
        send_one(16'd2000, 16'h8000, 18'h1FFFF, 18'h0, 1'b0, 1'b0, "R6");
        // R5 clamp captured while clear is held: set wins
        @(negedge clk); ovf_clear = 1'b1;
        send_one(16'h8000, 16'd0, 18'h1FFFF, 18'h20000, 1'b0, 1'b1, "R5");
        @(negedge clk);
        ovf_clear = 1'b0;
        chk(ovf_flag == 1'b0, "R5", "held clear drops flag next cycle", ovf_flag, 0);

        // random phase with back-pressure, scoreboard
        prev_stall = 1'b0;
        prev_i = '0;
        prev_q = '0;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            if (prev_stall) begin
                chk(out_valid && out_i == prev_i && out_q == prev_q, "R7",
                    "stalled output held", out_i, prev_i);
            end
            out_ready = ($urandom % 4) != 0;
            in_valid  = ($urandom % 10) < 7;
            in_i = 16'($urandom);
            in_q = 16'($urandom);
            if (($urandom % 4) == 0) gain = 18'($urandom % 32'h10000);
            else gain = 18'($urandom);
            offset = 18'($urandom);
            complex_mode = 1'($urandom);
            #1;
            if ((cyc % 16) == 0)
                chk(in_ready == out_ready, "R1", "in_ready follows out_ready", in_ready, out_ready);
            if (out_valid && out_ready) begin
                if (scb.size() == 0) begin
                    chk(1'b0, "R2", "unexpected output beat", 1, 0);
                end else begin
                    exp_t e;
                    e = scb.pop_front();
                    chk($signed(out_i) == e.vi, "R3", "random out_i", $signed(out_i), e.vi);
                    chk($signed(out_q) == e.vq, "R6", "random out_q", $signed(out_q), e.vq);
                    if (e.sat)
                        chk(ovf_flag == 1'b1, "R4", "flag after random clamp", ovf_flag, 1);
                end
            end
            if (in_valid && in_ready)
                scb.push_back(pair_model(in_i, in_q, gain, offset, complex_mode));
            prev_stall = out_valid && !out_ready;
            prev_i = out_i;
            prev_q = out_q;
        end

        // drain
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        for (int k = 0; k < 8; k++) begin
            #1;
            if (out_valid && scb.size() != 0) begin
                exp_t e;
                e = scb.pop_front();
                chk($signed(out_i) == e.vi, "R3", "drain out_i", $signed(out_i), e.vi);
                chk($signed(out_q) == e.vq, "R6", "drain out_q", $signed(out_q), e.vq);
            end
            @(negedge clk);
        end
        chk(scb.size() == 0, "R2", "all accepted beats delivered", scb.size(), 0);

        done = 1'b1;
        summary();
    end

endmodule